// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the clock sent to an SD card from the host clock. A nine-bit control word sets it up. The low byte picks the division ratio, and the top bit starts or stops the card clock. In the low byte, a single set bit picks a power-of-two divisor between 4 and 512; moving that bit one place lower halves the divisor. A byte of zero selects division by two. A separate bypass input passes the host clock straight through whenever the clock is enabled.

The card clock must never show a shortened pulse. For that reason, a new divisor, enable or bypass setting is taken up only at the end of a low phase of the card clock. A high phase that is already under way always runs to its full length.

A companion output gates the clock-and-wait logic. It is ordered against the card clock: it turns on only after the card clock is running, and it turns off on the first host edge after the enable bit clears, before the card clock actually stops.

Top module: `sdclk_gen`

## Requirements
- R1: With bit k (0..7) as the highest set bit of `clk_ctl[7:0]`, `bypass_sel` low and `clk_ctl[8]` high, the card clock divides the host clock by 2^(k+2). It is high for 2^(k+1) host cycles and low for 2^(k+1) host cycles, so 0x80 gives 512 and 0x01 gives 4.
- R2: A divisor byte of 0x00 divides by two: one host cycle high, one host cycle low.
- R3: A divisor byte with more than one bit set behaves like its highest set bit alone. For example, 0x0A acts as 0x08 and 0xC0 acts as 0x80.
- R4: With `clk_ctl[8]` high and `bypass_sel` high, the card clock follows the host clock: high while the host clock is high, low while it is low. Leaving bypass resumes division by the selected byte.
- R5: With `clk_ctl[8]` low, the card clock is held low, whatever the divisor byte and `bypass_sel` are. Clearing the bit during a high phase lets that high phase and the following low phase finish at full length; the clock then stays low.
- R6: During and after reset, until the enable bit is set, `card_clk` and `wait_gate` are low.
- R7: A new divisor is taken up only when a low phase ends. A high phase in progress, and the low phase after it, keep the old length.
- R8: `wait_gate` is high only while `wait_ctl_en` and `clk_ctl[8]` are high and the card clock is running. It rises one host cycle after the first card-clock rising edge. It falls on the first host edge after `clk_ctl[8]` clears.
- R9: When the clock is started from the stopped state in divided mode, the first card-clock rising edge comes at the first host edge that sees the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ctl | input | 9 | Bits 7:0 divisor select, bit 8 card clock enable |
| bypass_sel | input | 1 | Pass the host clock through undivided |
| wait_ctl_en | input | 1 | Request to enable the clock-and-wait logic |
| card_clk | output | 1 | Clock to the SD card |
| wait_gate | output | 1 | Enable for the clock-and-wait logic |

## Verification
The bench switches the divisor while the card clock is high. A design that took the new setting at once would cut that high pulse short, or would use the new length for the low phase that follows. It clears the enable bit just after a rising edge; a design that stopped at once would leave a truncated pulse. It drives bytes with several bits set, to catch a decoder that lets the lowest bit win or that merges bits into a wrong ratio. It also moves into and out of bypass, and checks that the wait gate lags the clock at start and leads it at stop. A design that ordered the wait gate wrongly would have it on while the card clock is dead.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_DIV = 2'd1,
    MODE_BYP = 2'd2
  } clk_mode_e;
endpackage

// File: rtl/sdclk_rst_sync.sv
module sdclk_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_out = stage2_q;
endmodule

// File: rtl/sdclk_sel_decode.sv
module sdclk_sel_decode #(
  parameter int SEL_W = 8,
  parameter int CNT_W = SEL_W
) (
  input  logic [SEL_W-1:0] sel_byte,
  output logic [CNT_W-1:0] half_last
);
  // half period = 2^(msb+1) host cycles, or 1 for a zero byte; later bits override
  always_comb begin
    half_last = '0;
    for (int i = 0; i < SEL_W; i++) begin
      if (sel_byte[i]) begin
        for (int j = 0; j < CNT_W; j++) begin
          half_last[j] = (j <= i);
        end
      end
    end
  end
endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core
  import sdclk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_en,
  input  logic             req_byp,
  input  logic [CNT_W-1:0] req_last,
  output logic             div_clk,
  output logic             byp_on,
  output logic             running
);
  clk_mode_e        mode_q, mode_n, req_mode;
  logic [CNT_W-1:0] last_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             div_q, div_n;
  logic             upd;

  always_comb begin
    if (!req_en)      req_mode = MODE_OFF;
    else if (req_byp) req_mode = MODE_BYP;
    else              req_mode = MODE_DIV;
  end

  // settings are taken only when the output is low and a low phase ends
  assign upd = !div_q && ((mode_q != MODE_DIV) || (cnt_q == last_q));

  always_comb begin
    mode_n = mode_q;
    cnt_n  = cnt_q;
    div_n  = div_q;
    if (upd) begin
      mode_n = req_mode;
      cnt_n  = '0;
      div_n  = (req_mode == MODE_DIV) && (mode_q != MODE_BYP);
    end else if (mode_q == MODE_DIV) begin
      if (cnt_q == last_q) begin
        cnt_n = '0;
        div_n = !div_q;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      last_q <= '0;
    end else if (upd) begin
      mode_q <= mode_n;
      last_q <= req_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      div_q <= div_n;
    end
  end

  assign div_clk = div_q;
  assign byp_on  = (mode_q == MODE_BYP);
  assign running = (mode_q != MODE_OFF);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(last_q) |-> !$past(div_q));

  // R1
  half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DIV && div_q && cnt_q != last_q) |=> div_q);

  // R5
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF) |-> !div_q);
endmodule

// File: rtl/sdclk_byp_gate.sv
module sdclk_byp_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic byp_on,
  output logic gated_clk,
  output logic gate_open
);
  logic gate_q;

  // enable captured while the host clock is low, so the AND cannot glitch
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= byp_on;
  end

  assign gated_clk = clk & gate_q;
  assign gate_open = gate_q;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int SEL_W = 8
) (
  input  logic         hclk,
  input  logic         rst_n,
  input  logic [SEL_W:0] clk_ctl,
  input  logic         bypass_sel,
  input  logic         wait_ctl_en,
  output logic         card_clk,
  output logic         wait_gate
);
  localparam int CNT_W = SEL_W;

  logic             rst_sync_n;
  logic [CNT_W-1:0] req_last;
  logic             div_clk, byp_on, running;
  logic             byp_clk, gate_open;
  logic             wait_q, wait_n;

  sdclk_rst_sync i_rst (
    .clk       (hclk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  sdclk_sel_decode #(.SEL_W(SEL_W), .CNT_W(CNT_W)) i_dec (
    .sel_byte  (clk_ctl[SEL_W-1:0]),
    .half_last (req_last)
  );

  sdclk_div_core #(.CNT_W(CNT_W)) i_core (
    .clk      (hclk),
    .rst_n    (rst_sync_n),
    .req_en   (clk_ctl[SEL_W]),
    .req_byp  (bypass_sel),
    .req_last (req_last),
    .div_clk  (div_clk),
    .byp_on   (byp_on),
    .running  (running)
  );

  sdclk_byp_gate i_gate (
    .clk       (hclk),
    .rst_n     (rst_sync_n),
    .byp_on    (byp_on),
    .gated_clk (byp_clk),
    .gate_open (gate_open)
  );

  // wait gate: on after the clock runs, off as soon as the enable bit drops
  assign wait_n = wait_ctl_en & clk_ctl[SEL_W] & running;

  always_ff @(posedge hclk or negedge rst_sync_n) begin
    if (!rst_sync_n) wait_q <= 1'b0;
    else             wait_q <= wait_n;
  end

  assign card_clk  = div_clk | byp_clk;
  assign wait_gate = wait_q;

  // R4
  byp_excl_chk: assert property (@(posedge hclk) disable iff (!rst_sync_n)
    gate_open |-> !div_clk);

  // R8
  wait_order_chk: assert property (@(posedge hclk) disable iff (!rst_sync_n)
    wait_q |-> running);

  // R8
  wait_drop_chk: assert property (@(posedge hclk) disable iff (!rst_sync_n)
    $past(!clk_ctl[SEL_W]) |-> !wait_q);
endmodule

// File: tb/test_sdclk_gen.sv
module test_sdclk_gen;
  logic       hclk;
  logic       rst_n;
  logic [8:0] clk_ctl;
  logic       bypass_sel;
  logic       wait_ctl_en;
  logic       card_clk;
  logic       wait_gate;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;
  logic prev_s = 1'b0;
  logic cur_s  = 1'b0;

  // {divisor byte, expected half period in host cycles}
  localparam logic [16:0] VEC [0:10] = '{
    {8'h00, 9'd1},   {8'h01, 9'd2},   {8'h02, 9'd4},   {8'h04, 9'd8},
    {8'h08, 9'd16},  {8'h10, 9'd32},  {8'h20, 9'd64},  {8'h40, 9'd128},
    {8'h80, 9'd256}, {8'h0A, 9'd16},  {8'hC0, 9'd256}
  };

  sdclk_gen i_sdclk_gen (
    .hclk        (hclk),
    .rst_n       (rst_n),
    .clk_ctl     (clk_ctl),
    .bypass_sel  (bypass_sel),
    .wait_ctl_en (wait_ctl_en),
    .card_clk    (card_clk),
    .wait_gate   (wait_gate)
  );

  initial hclk = 1'b0;
  always #4 hclk = ~hclk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge hclk);
    #2;
    prev_s = cur_s;
    cur_s  = card_clk;
  endtask

  task automatic drive(input logic [8:0] c, input logic b, input logic w);
    @(negedge hclk);
    #1;
    clk_ctl     = c;
    bypass_sel  = b;
    wait_ctl_en = w;
  endtask

  task automatic wait_rise(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      step();
      if (!prev_s && cur_s) begin
        ok = 1;
        break;
      end
    end
  endtask

  // starts on the first high sample of a phase, ends on the next rising sample
  task automatic measure(output int hi, output int lo);
    hi = 1;
    lo = 0;
    for (int i = 0; i < 3000; i++) begin
      step();
      if (!cur_s) break;
      hi++;
    end
    lo = 1;
    for (int i = 0; i < 3000; i++) begin
      step();
      if (cur_s) break;
      lo++;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge hclk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    bit ok;
    int hi, lo;
    int zeros;
    clk_ctl     = 9'h000;
    bypass_sel  = 1'b0;
    wait_ctl_en = 1'b0;
    rst_n       = 1'b0;
    repeat (5) @(posedge hclk);
    #2;
    chk(card_clk == 1'b0, "R6 clock in reset", card_clk, 0);
    chk(wait_gate == 1'b0, "R6 wait gate in reset", wait_gate, 0);
    @(negedge hclk);
    rst_n = 1'b1;
    repeat (4) step();
    chk(card_clk == 1'b0, "R6 clock after reset", card_clk, 0);
    chk(wait_gate == 1'b0, "R6 wait gate after reset", wait_gate, 0);

    // R5: disabled with a divisor and bypass requested, output stays low
    drive(9'h004, 1'b1, 1'b1);
    zeros = 0;
    for (int i = 0; i < 200; i++) begin
      step();
      if (!cur_s) zeros++;
      @(negedge hclk);
      #2;
      if (!card_clk) zeros++;
    end
    chk(zeros == 400, "R5 disabled ignores byte and bypass", zeros, 400);
    chk(wait_gate == 1'b0, "R8 wait gate while disabled", wait_gate, 0);

    // R9 / R8: start from stopped, divide by 8
    drive(9'h102, 1'b0, 1'b1);
    step();
    chk(cur_s == 1'b1, "R9 first edge on first host edge", cur_s, 1);
    chk(wait_gate == 1'b0, "R8 wait gate lags clock start", wait_gate, 0);
    step();
    chk(wait_gate == 1'b1, "R8 wait gate on after clock", wait_gate, 1);
    drive(9'h002, 1'b0, 1'b1);
    step();
    chk(wait_gate == 1'b0, "R8 wait gate drops at first edge", wait_gate, 0);
    zeros = 0;
    for (int i = 0; i < 12; i++) step();
    for (int i = 0; i < 100; i++) begin
      step();
      if (!cur_s) zeros++;
    end
    chk(zeros == 100, "R5 clock stopped after disable", zeros, 100);

    // R1 R2 R3: table walk
    drive(9'h100, 1'b0, 1'b0);
    for (int v = 0; v < 11; v++) begin
      drive({1'b1, VEC[v][16:9]}, 1'b0, 1'b0);
      wait_rise(ok);
      measure(hi, lo);
      if (VEC[v][16:9] == 8'h00)
        chk(ok && hi == 1 && lo == 1, "R2 divide by two", hi, 1);
      else if (VEC[v][16:9] == 8'h0A || VEC[v][16:9] == 8'hC0)
        chk(ok && hi == int'(VEC[v][8:0]) && lo == int'(VEC[v][8:0]),
            "R3 highest bit wins", hi, int'(VEC[v][8:0]));
      else
        chk(ok && hi == int'(VEC[v][8:0]) && lo == int'(VEC[v][8:0]),
            "R1 one-hot divisor", hi, int'(VEC[v][8:0]));
    end

    // R7: change 0x80 -> 0x00 just after a rising edge
    drive(9'h180, 1'b0, 1'b0);
    wait_rise(ok);
    wait_rise(ok);
    drive(9'h100, 1'b0, 1'b0);
    hi = 1;
    for (int i = 0; i < 600; i++) begin
      step();
      if (!cur_s) break;
      hi++;
    end
    chk(hi == 256, "R7 high phase keeps old length", hi, 256);
    lo = 1;
    for (int i = 0; i < 600; i++) begin
      step();
      if (cur_s) break;
      lo++;
    end
    chk(lo == 256, "R7 low phase keeps old length", lo, 256);
    measure(hi, lo);
    chk(hi == 1 && lo == 1, "R7 new divisor after low phase", hi, 1);

    // R5: clear enable mid high phase with divisor 256
    drive(9'h140, 1'b0, 1'b0);
    wait_rise(ok);
    wait_rise(ok);
    drive(9'h040, 1'b0, 1'b0);
    hi = 1;
    for (int i = 0; i < 600; i++) begin
      step();
      if (!cur_s) break;
      hi++;
    end
    chk(hi == 128, "R5 no shortened pulse on stop", hi, 128);
    zeros = 0;
    for (int i = 0; i < 600; i++) begin
      step();
      if (!cur_s) zeros++;
    end
    chk(zeros == 600, "R5 stays low after stop", zeros, 600);

    // R4: bypass follows host clock
    drive(9'h101, 1'b1, 1'b0);
    repeat (4) step();
    zeros = 0;
    for (int i = 0; i < 16; i++) begin
      @(posedge hclk);
      #2;
      if (card_clk) zeros++;
      @(negedge hclk);
      #2;
      if (!card_clk) zeros++;
    end
    chk(zeros == 32, "R4 bypass follows host clock", zeros, 32);

    // R4: leaving bypass resumes division by four
    drive(9'h101, 1'b0, 1'b0);
    wait_rise(ok);
    measure(hi, lo);
    chk(ok && hi == 2 && lo == 2, "R4 leave bypass to divided", hi, 2);

    // R4 / R5: bypass with enable clear stays low
    drive(9'h001, 1'b1, 1'b0);
    repeat (8) step();
    zeros = 0;
    for (int i = 0; i < 50; i++) begin
      @(posedge hclk);
      #2;
      if (!card_clk) zeros++;
      @(negedge hclk);
      #2;
      if (!card_clk) zeros++;
    end
    chk(zeros == 100, "R4 bypass ignored when disabled", zeros, 100);

    done = 1;
    summary();
    $finish;
  end
endmodule